// File: doc/BRIEF.md
# Condition-Flag ALU with Branch Evaluation

This block is the execute-stage slice of a 64-bit integer datapath. It computes add, subtract and bitwise AND, and it also runs compare and test operations, which set flags but write no register. Every flag-setting operation loads four condition flags into a small flag register: zero, carry/borrow, sign and overflow. The flags are then held until the next flag-setting operation.

A branch evaluator reads the latched flags. It reports whether a conditional or unconditional jump is taken. It also forms the jump target by adding a sign-extended 8-bit displacement to the current instruction pointer.

The block has no instruction fetch, decode, memory or register file. A surrounding pipeline presents one operation per cycle with a valid strobe. That pipeline consumes `result` under `wr_en`, and it consumes `taken`/`target` to steer fetch.

Top module: `cond_alu`

## Requirements
- R1: ADD (opcode 1) drives `result` = x + y modulo 2^64 and asserts `wr_en`. At the next rising edge, `flags` is loaded with bit 0 ZF (result zero), bit 1 CF (carry out of bit 63), bit 2 SF (result bit 63) and bit 3 OF (signed overflow).
- R2: SUB (opcode 2) drives `result` = y − x and asserts `wr_en`. The flags are loaded with CF meaning a borrow (x > y unsigned), OF meaning signed overflow of y − x, and ZF/SF taken from the result.
- R3: AND (opcode 3) drives `result` = x & y and asserts `wr_en`. The flags are loaded with ZF and SF from the result, and with CF and OF cleared.
- R4: CMP (opcode 4) loads the flags exactly as SUB would and keeps `wr_en` low.
- R5: TEST (opcode 5) loads the flags exactly as AND would and keeps `wr_en` low.
- R6: `flags` changes only at a rising edge where `op_valid` is high with opcode 1 to 5. Otherwise it holds. This includes NOP (0), the jumps (6, 7, 8), unused opcodes 9 to 15, and any cycle with `op_valid` low.
- R7: While `rst_n` is low, `flags` is cleared to 0000.
- R8: JZ (opcode 6) raises `taken` when the latched ZF is 1. JS (opcode 7) raises it when the latched SF is 1. JMP (opcode 8) raises it unconditionally, ignoring the flags. `taken` is low for every other opcode and whenever `op_valid` is low.
- R9: `target` equals `ip` plus `offset` sign-extended from 8 bits, modulo 2^64, in every cycle.
- R10: `wr_en` is low whenever `op_valid` is low and for every opcode other than 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 4 | Operation select |
| opnd_x | input | 64 | First operand |
| opnd_y | input | 64 | Second operand |
| ip | input | 64 | Current instruction pointer |
| offset | input | 8 | Signed branch displacement |
| result | output | 64 | ALU result |
| wr_en | output | 1 | Register write enable |
| flags | output | 4 | Latched {OF, SF, CF, ZF} |
| taken | output | 1 | Jump is taken |
| target | output | 64 | Jump target address |

## Verification
Two functions meet in the same cycle: the flag register loading from the current operation, and the branch evaluator judging a jump against the previously latched flags. The bench provokes this with back-to-back sequences: a compare or test followed at once by JZ or JS, and a jump issued while other flag values are held. It also provokes it with random streams that interleave flag-setting operations and jumps. A reference model in the bench predicts which flag value each jump must see, namely the one latched at the preceding edge. Every `taken` value and every post-edge `flags` value is compared against that model.

// File: rtl/cond_alu.sv
module cond_alu #(
  parameter int W    = 64,
  parameter int OFFW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [3:0]      opcode,
  input  logic [W-1:0]    opnd_x,
  input  logic [W-1:0]    opnd_y,
  input  logic [W-1:0]    ip,
  input  logic [OFFW-1:0] offset,
  output logic [W-1:0]    result,
  output logic            wr_en,
  output logic [3:0]      flags,
  output logic            taken,
  output logic [W-1:0]    target
);
  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_AND  = 4'd3;
  localparam logic [3:0] OP_CMP  = 4'd4;
  localparam logic [3:0] OP_TEST = 4'd5;
  localparam logic [3:0] OP_JZ   = 4'd6;
  localparam logic [3:0] OP_JS   = 4'd7;
  localparam logic [3:0] OP_JMP  = 4'd8;

  logic [W:0]   sum_ext, dif_ext;
  logic [W-1:0] alu_val;
  logic         c_nxt, o_nxt, sets_flags;

  assign sum_ext = {1'b0, opnd_x} + {1'b0, opnd_y};
  assign dif_ext = {1'b0, opnd_y} - {1'b0, opnd_x};

  always_comb begin
    alu_val = '0;
    c_nxt   = 1'b0;
    o_nxt   = 1'b0;
    case (opcode)
      OP_ADD: begin
        alu_val = sum_ext[W-1:0];
        c_nxt   = sum_ext[W];
        o_nxt   = (opnd_x[W-1] == opnd_y[W-1]) && (alu_val[W-1] != opnd_x[W-1]);
      end
      OP_SUB, OP_CMP: begin
        alu_val = dif_ext[W-1:0];
        c_nxt   = dif_ext[W];
        o_nxt   = (opnd_x[W-1] != opnd_y[W-1]) && (alu_val[W-1] != opnd_y[W-1]);
      end
      OP_AND, OP_TEST: alu_val = opnd_x & opnd_y;
      default: ;
    endcase
  end

  assign sets_flags = op_valid && (opcode >= OP_ADD) && (opcode <= OP_TEST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          flags <= 4'b0000;
    else if (sets_flags) flags <= {o_nxt, alu_val[W-1], c_nxt, alu_val == '0};

  assign result = alu_val;
  assign wr_en  = op_valid && (opcode == OP_ADD || opcode == OP_SUB || opcode == OP_AND);
  assign taken  = op_valid && ((opcode == OP_JZ && flags[0]) ||
                               (opcode == OP_JS && flags[2]) ||
                               (opcode == OP_JMP));
  assign target = ip + {{(W-OFFW){offset[OFFW-1]}}, offset};

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && opcode >= OP_ADD && opcode <= OP_TEST) |=> $stable(flags)); // R6
  AST_ZF_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode >= OP_ADD && opcode <= OP_TEST) |=> flags[0] == ($past(result) == '0)); // R1
  AST_LOGIC_CLEARS_CO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (opcode == OP_AND || opcode == OP_TEST)) |=> !flags[1] && !flags[3]); // R3
  AST_NO_WRITE_ON_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_CMP || opcode == OP_TEST || !op_valid) |-> !wr_en); // R4
  AST_JZ_FOLLOWS_ZF: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == OP_JZ) |-> taken == flags[0]); // R8
  AST_JMP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == OP_JMP) |-> taken); // R8
endmodule

// File: tb/cond_alu_bench.sv
module cond_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [63:0] opnd_x = '0, opnd_y = '0, ip = '0;
  logic [7:0]  offset = '0;
  logic [63:0] result, target;
  logic        wr_en, taken;
  logic [3:0]  flags;

  int n_run = 0, n_fail = 0;
  logic [3:0] mdl_flags = 4'b0000;

  cond_alu u_cond_alu (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .opnd_x(opnd_x), .opnd_y(opnd_y), .ip(ip), .offset(offset), .result(result),
    .wr_en(wr_en), .flags(flags), .taken(taken), .target(target));

  always #4 clk = ~clk;

  function automatic logic [63:0] ref_res(input logic [3:0] op, input logic [63:0] x, y);
    case (op)
      4'd1: return x + y;
      4'd2, 4'd4: return y - x;
      4'd3, 4'd5: return x & y;
      default: return 64'd0;
    endcase
  endfunction

  function automatic logic [3:0] ref_flags(input logic [3:0] op, input logic [63:0] x, y);
    logic [64:0] u, s;
    logic [63:0] r;
    logic c, o;
    c = 0; o = 0;
    r = ref_res(op, x, y);
    if (op == 4'd1) begin
      u = {1'b0, x} + {1'b0, y}; s = {x[63], x} + {y[63], y};
      c = u[64]; o = s[64] ^ s[63];
    end else if (op == 4'd2 || op == 4'd4) begin
      c = (x > y); s = {y[63], y} - {x[63], x};
      o = s[64] ^ s[63];
    end
    return {o, r[63], c, (r == 64'd0)};
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6, 4'd7, 4'd8: return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input logic v, input logic [3:0] op, input logic [63:0] x, y,
                        input logic [63:0] pc, input logic [7:0] off);
    logic fs, exp_tk, exp_we;
    logic [63:0] exp_tg;
    @(negedge clk);
    op_valid = v; opcode = op; opnd_x = x; opnd_y = y; ip = pc; offset = off;
    #1;
    exp_we = v && (op == 4'd1 || op == 4'd2 || op == 4'd3);
    exp_tk = v && ((op == 4'd6 && mdl_flags[0]) || (op == 4'd7 && mdl_flags[2]) || op == 4'd8);
    exp_tg = pc + {{56{off[7]}}, off};
    check(wr_en == exp_we, exp_we ? tag_of(op) : "R10", "wr_en", 64'(wr_en), 64'(exp_we));
    if (v && op >= 4'd1 && op <= 4'd5)
      check(result == ref_res(op, x, y), tag_of(op), "result", result, ref_res(op, x, y));
    check(taken == exp_tk, "R8", "taken", 64'(taken), 64'(exp_tk));
    check(target == exp_tg, "R9", "target", target, exp_tg);
    fs = v && op >= 4'd1 && op <= 4'd5;
    @(posedge clk); #1;
    if (fs) mdl_flags = ref_flags(op, x, y);
    check(flags == mdl_flags, fs ? tag_of(op) : "R6", "flags", 64'(flags), 64'(mdl_flags));
  endtask

  function automatic logic [63:0] pick(input int k);
    case (k % 6)
      0: return 64'd0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h8000_0000_0000_0000;
      3: return 64'h7FFF_FFFF_FFFF_FFFF;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #20; #1;
    check(flags == 4'b0000, "R7", "reset flags", 64'(flags), 64'd0);
    check(taken == 1'b0 && wr_en == 1'b0, "R7", "reset idle outputs", 64'({taken, wr_en}), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    run_op(1, 4'd6, 0, 0, 64'h1000, 8'h10);                              // R7 JZ after reset not taken
    run_op(1, 4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0);                // R1 carry + zero
    run_op(1, 4'd6, 0, 0, 64'h2000, 8'h80);                              // R8 JZ taken, R9 negative offset
    run_op(1, 4'd1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 0);                // R1 overflow + sign
    run_op(1, 4'd7, 0, 0, 64'h0, 8'hFF);                                 // R8 JS taken, R9 wrap
    run_op(1, 4'd2, 64'd5, 64'd3, 0, 0);                                  // R2 borrow
    run_op(1, 4'd2, 64'd1, 64'h8000_0000_0000_0000, 0, 0);                // R2 signed overflow
    run_op(1, 4'd4, 64'd42, 64'd42, 0, 0);                                // R4 equal -> ZF, no write
    run_op(1, 4'd6, 0, 0, 64'h40, 8'h40);                                 // R8 back-to-back JZ
    run_op(1, 4'd5, 64'hF0, 64'h0F, 0, 0);                                // R5 test zero
    run_op(1, 4'd3, 64'hFFFF_0000_0000_0000, 64'h8F00_0000_0000_0001, 0, 0); // R3 sign, CF/OF clear
    run_op(0, 4'd1, 64'd0, 64'd0, 0, 0);                                  // R6 invalid add holds
    run_op(1, 4'd8, 0, 0, 64'h100, 8'h7F);                                // R8 JMP ignores flags
    run_op(1, 4'd12, 64'd0, 64'd0, 0, 0);                                 // R6 unused opcode holds
    for (int i = 0; i < 600; i++) begin
      logic [3:0] op;
      op = (($urandom % 10) == 0) ? 4'($urandom) : 4'($urandom % 9);
      run_op(($urandom % 8) != 0, op, pick($urandom), pick($urandom),
             {$urandom, $urandom}, 8'($urandom));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule